// File: doc/BRIEF.md
# Indexed Colour Lookup Register File

This block holds a 256-entry colour lookup table and connects it to a byte-wide host I/O bus through two ports. The host first writes an entry number to the index port. It then makes three back-to-back accesses to the data port to load or fetch that entry, one colour component per access. Each component is six bits wide. A small sequencer tracks which component comes next. After the last component it moves the index on to the following entry, so the host can stream through the whole table without rewriting the index.

A separate lookup port serves the pixel pipeline. The pipeline presents an entry number and gets back a packed 8-bit colour one clock later. That colour is built from the top bits of each stored component: three bits of red, three bits of green and two bits of blue.

The sequencer has three named states. `PH_RED` expects the red component, `PH_GRN` expects green and `PH_BLU` expects blue. Its transitions are:
- `ADVANCE_RG`: a data-port access in `PH_RED` moves it to `PH_GRN`.
- `ADVANCE_GB`: a data-port access in `PH_GRN` moves it to `PH_BLU`.
- `WRAP_BR`: a data-port access in `PH_BLU` moves it back to `PH_RED` and increments the index.
- `RESTART`: an index-port write forces `PH_RED` from any state.
- `HOLD`: any other cycle leaves the state unchanged.

Top module: `clut_bank`

## Requirements
- R1: After reset the index is 00h and the sequencer is in `PH_RED`. The first three data writes therefore land in entry 0 as red, green and blue.
- R2: A write to the index port (`host_sel_data`=0) loads the entry number from `host_wdata[7:0]`. A read of the index port returns 00h on `host_rdata` and changes neither the index nor the sequencer state.
- R3: A write to the index port returns the sequencer to `PH_RED`, even partway through an entry. Components already written stay in the table.
- R4: Data-port writes store `host_wdata[5:0]` into red, then green, then blue of the selected entry. Bits 7:6 of the byte are ignored.
- R5: During a data-port access, `host_rdata` shows the component that the sequencer is at, in the same cycle. Bits 7:6 read as zero. Three successive reads return red, green, blue.
- R6: The index is held after the red and green accesses. After the blue access it increments by one, and it wraps from FFh to 00h.
- R7: Reads and writes share one sequencer, so a mix of reads and writes steps through the components in order.
- R8: `pix_rgb` equals {R[5:3], G[5:3], B[5:4]} of the entry named by `pix_idx` on the previous clock edge.
- R9: A component write made at one clock edge appears on `pix_rgb` after the next edge, for a `pix_idx` held on that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel_data | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the access cycle |
| pix_idx | input | 8 | Pixel lookup entry number |
| pix_rgb | output | 8 | Packed 3/3/2 colour, one cycle after `pix_idx` |

## Verification
The whole table is loaded in one streamed run of 768 writes. Each byte is a different arithmetic mix of entry and component, with the upper two bits varying, so any swapped component, wrong entry or stored upper bit shows up. The table is then swept through the lookup port and read back in a second streamed run. Reading entry 0 straight after the 256th entry, without rewriting the index, separates a correct FFh-to-00h wrap from a stuck or misstepped index. Short targeted sequences exercise:
- the restart partway through an entry;
- mixed reads and writes on the shared sequencer;
- index-port reads that must have no effect;
- the exact cycle in which a fresh blue write reaches the pixel output.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_t;

    localparam int NUM_COMP = 3;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int BUS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic                acc_data,
    input  logic [BUS_W-1:0]    acc_wdata,
    output logic [IDX_W-1:0]    idx,
    output phase_t              phase,
    output logic [NUM_COMP-1:0] comp_we
);

    phase_t           state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             idx_load, data_acc;

    assign idx_load = acc_en && !acc_data && acc_wr;
    assign data_acc = acc_en && acc_data;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state: RESTART, ADVANCE_RG, ADVANCE_GB, WRAP_BR, HOLD
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (idx_load) begin
            state_d = PH_RED;
            idx_d   = acc_wdata[IDX_W-1:0];
        end else if (data_acc) begin
            unique case (state_q)
                PH_RED:  state_d = PH_GRN;
                PH_GRN:  state_d = PH_BLU;
                PH_BLU: begin
                    state_d = PH_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default: state_d = PH_RED;
            endcase
        end
    end

    // Outputs: per-component write enables
    always_comb begin
        comp_we = '0;
        if (data_acc && acc_wr) begin
            unique case (state_q)
                PH_RED:  comp_we[0] = 1'b1;
                PH_GRN:  comp_we[1] = 1'b1;
                PH_BLU:  comp_we[2] = 1'b1;
                default: comp_we    = '0;
            endcase
        end
    end

    assign idx   = idx_q;
    assign phase = state_q;

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_load |=> (idx_q == $past(acc_wdata[IDX_W-1:0]))); // R2
    AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        idx_load |=> (state_q == PH_RED)); // R3
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_load && data_acc && state_q == PH_BLU) |=> (idx_q == $past(idx_q) + 1'b1)); // R6
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_load && data_acc && state_q != PH_BLU) |=> $stable(idx_q)); // R6

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int R_BITS = 3,
    parameter int G_BITS = 3,
    parameter int B_BITS = 2
) (
    input  logic                           clk,
    input  logic [NUM_COMP-1:0]            we,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [COMP_W-1:0]              wr_comp,
    input  phase_t                         rd_phase,
    output logic [COMP_W-1:0]              rd_comp,
    input  logic [IDX_W-1:0]               pix_idx,
    output logic [R_BITS+G_BITS+B_BITS-1:0] pix_rgb
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [COMP_W-1:0] mem [NUM_COMP][ENTRIES];
    logic [COMP_W-1:0] host_val [NUM_COMP];

    // Component write port
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_COMP; c++) begin
            if (we[c]) mem[c][wr_idx] <= wr_comp;
        end
    end

    // Host read-back taps, one per component
    for (genvar c = 0; c < NUM_COMP; c++) begin : g_tap
        assign host_val[c] = mem[c][wr_idx];
    end

    always_comb begin
        unique case (rd_phase)
            PH_RED:  rd_comp = host_val[0];
            PH_GRN:  rd_comp = host_val[1];
            PH_BLU:  rd_comp = host_val[2];
            default: rd_comp = '0;
        endcase
    end

    // Pixel lookup, one-cycle latency, MSB truncation
    always_ff @(posedge clk) begin
        pix_rgb <= {mem[0][pix_idx][COMP_W-1 -: R_BITS],
                    mem[1][pix_idx][COMP_W-1 -: G_BITS],
                    mem[2][pix_idx][COMP_W-1 -: B_BITS]};
    end

endmodule

// File: rtl/clut_bank.sv
module clut_bank
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int BUS_W  = 8,
    parameter int COMP_W = 6,
    parameter int R_BITS = 3,
    parameter int G_BITS = 3,
    parameter int B_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_en,
    input  logic                    host_wr,
    input  logic                    host_sel_data,
    input  logic [BUS_W-1:0]        host_wdata,
    output logic [BUS_W-1:0]        host_rdata,
    input  logic [IDX_W-1:0]        pix_idx,
    output logic [R_BITS+G_BITS+B_BITS-1:0] pix_rgb
);

    localparam int PAD_W = BUS_W - COMP_W;

    logic [IDX_W-1:0]    cur_idx;
    phase_t              cur_phase;
    logic [NUM_COMP-1:0] comp_we;
    logic [COMP_W-1:0]   rd_comp;

    clut_seq #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (host_en),
        .acc_wr    (host_wr),
        .acc_data  (host_sel_data),
        .acc_wdata (host_wdata),
        .idx       (cur_idx),
        .phase     (cur_phase),
        .comp_we   (comp_we)
    );

    clut_store #(
        .IDX_W(IDX_W), .COMP_W(COMP_W),
        .R_BITS(R_BITS), .G_BITS(G_BITS), .B_BITS(B_BITS)
    ) u_store (
        .clk      (clk),
        .we       (comp_we),
        .wr_idx   (cur_idx),
        .wr_comp  (host_wdata[COMP_W-1:0]),
        .rd_phase (cur_phase),
        .rd_comp  (rd_comp),
        .pix_idx  (pix_idx),
        .pix_rgb  (pix_rgb)
    );

    assign host_rdata = host_sel_data ? {{PAD_W{1'b0}}, rd_comp} : '0;

    AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[BUS_W-1:COMP_W] == '0); // R5
    AST_INDEX_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && !host_sel_data && !host_wr) |-> (host_rdata == '0)); // R2

endmodule

// File: tb/tb_clut_bank.sv
`timescale 1ns/1ps
module tb_clut_bank;

    localparam real CLK_NS = 10.0;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_en, host_wr, host_sel_data;
    logic [7:0] host_wdata, host_rdata, pix_idx, pix_rgb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [5:0] model [256][3];

    always #(CLK_NS/2) clk = ~clk;

    clut_bank dut (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
        .host_sel_data(host_sel_data), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    function automatic logic [7:0] pat(int i, int c);
        return 8'((i * 37 + c * 91 + 5) & 255);
    endfunction

    function automatic logic [7:0] packed_exp(int i);
        return {model[i][0][5:3], model[i][1][5:3], model[i][2][5:4]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic dport, input logic wr, input logic [7:0] wd,
                       output logic [7:0] rd);
        @(negedge clk);
        host_en = 1'b1; host_wr = wr; host_sel_data = dport; host_wdata = wd;
        #1 rd = host_rdata;
        @(posedge clk);
        #1 host_en = 1'b0; host_wr = 1'b0;
    endtask

    task automatic pix_chk(input string req, input int i);
        @(negedge clk); pix_idx = 8'(i);
        @(negedge clk);
        chk(req, pix_rgb, packed_exp(i));
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        host_en = 0; host_wr = 0; host_sel_data = 0; host_wdata = 0; pix_idx = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R2: index port reads as zero
        @(negedge clk); host_sel_data = 0; #1 chk("R2 idle index read", host_rdata, 8'h00);

        // R1: first writes after reset go to entry 0 red/green/blue
        for (int c = 0; c < 3; c++) begin
            acc(1, 1, 8'hC0 | 8'(c * 21 + 9), rd);
            model[0][c] = 6'(c * 21 + 9);
        end
        pix_chk("R1 reset entry0", 0);

        // R4/R6: stream the whole table from index 0, wrapping at the end
        acc(0, 1, 8'h00, rd);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) begin
                acc(1, 1, pat(i, c), rd);
                model[i][c] = pat(i, c)[5:0];
            end

        // R8: lookup sweep over every entry
        for (int i = 0; i < 256; i++) pix_chk("R8 pixel sweep", i);

        // R6: index wrapped FFh->00h, read entry 0 with no index write
        for (int c = 0; c < 3; c++) begin
            acc(1, 0, 8'h00, rd);
            chk("R6 wrap to entry0", rd, {2'b00, model[0][c]});
        end

        // R5: full streamed read-back
        acc(0, 1, 8'h00, rd);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) begin
                acc(1, 0, 8'hFF, rd);
                chk("R5 readback", rd, {2'b00, model[i][c]});
            end

        // R3: restart partway through an entry
        acc(0, 1, 8'd10, rd);
        acc(1, 1, 8'h11, rd); model[10][0] = 6'h11;
        acc(0, 1, 8'd20, rd);
        for (int c = 0; c < 3; c++) begin
            acc(1, 1, 8'(8'h2A + c), rd); model[20][c] = 6'(8'h2A + c);
        end
        acc(0, 1, 8'd10, rd);
        for (int c = 0; c < 3; c++) begin
            acc(1, 0, 8'h00, rd);
            chk("R3 restart keeps entry10", rd, {2'b00, model[10][c]});
        end
        acc(0, 1, 8'd20, rd);
        acc(1, 0, 8'h00, rd);
        chk("R3 restart red of entry20", rd, {2'b00, model[20][0]});

        // R7: mixed reads and writes share the sequencer
        acc(0, 1, 8'd30, rd);
        acc(1, 0, 8'h00, rd); chk("R7 mixed red", rd, {2'b00, model[30][0]});
        acc(1, 1, 8'hEA, rd); model[30][1] = 6'h2A;
        acc(1, 0, 8'h00, rd); chk("R7 mixed blue", rd, {2'b00, model[30][2]});
        acc(1, 0, 8'h00, rd); chk("R7 next entry red", rd, {2'b00, model[31][0]});
        pix_chk("R7 mixed green stored", 30);

        // R2: index port read has no effect on index or sequencer
        acc(0, 1, 8'd50, rd);
        acc(0, 0, 8'd99, rd); chk("R2 index read zero", rd, 8'h00);
        acc(1, 0, 8'h00, rd); chk("R2 index unchanged", rd, {2'b00, model[50][0]});

        // R9: write visible on pixel output after the following edge
        @(negedge clk); pix_idx = 8'd40;
        acc(0, 1, 8'd40, rd);
        acc(1, 1, 8'(model[40][0]), rd);
        acc(1, 1, 8'(model[40][1]), rd);
        acc(1, 1, {2'b00, ~model[40][2][5:4], model[40][2][3:0]}, rd);
        @(negedge clk);
        chk("R9 old value before update", pix_rgb, packed_exp(40));
        model[40][2] = {~model[40][2][5:4], model[40][2][3:0]};
        @(negedge clk);
        chk("R9 new value next cycle", pix_rgb, packed_exp(40));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule